// File: doc/BRIEF.md
# USB Bulk-IN FIFO Packetizing Writer

This block is the master-side write engine that moves a byte stream from a user source into a synchronous slave FIFO. The slave forwards that FIFO to the host as USB bulk-IN packets. The slave closes a host session when the strobe is released while it still has room. Because of that, the writer never lets go of the strobe in the middle of a packet. It first gathers one packet's worth of words from the source into a staging memory, then writes the packet as one unbroken burst. Each transfer ends with a short packet, so the session closes at exactly the requested length.

A transfer starts with a one-cycle start pulse. The pulse carries a byte count and a speed mode, and both are captured at that moment. The maximum packet is 512 bytes at high speed and 1024 bytes at super speed. Every packet but the last is exactly the maximum size. A tail that is not a whole number of bus words goes out as a partial-width write, with only the low byte enables set. When the length is an exact multiple of the maximum packet, including a length of zero, the writer adds one single-byte terminating write so that the transfer still closes. A done pulse follows the last accepted write.

The controller has six states:
- IDLE waits for start.
- PLAN either sizes the next packet from the remaining byte count or, if nothing remains, goes to TERM.
- FILL takes source words until the packet is staged, then goes to ARM.
- ARM waits at the packet boundary for the space flag, then goes to BURST.
- BURST drives the staged words. After the last word is accepted it goes to PLAN, TERM or IDLE.
- TERM issues the single-byte terminating write and returns to IDLE.

Top module: `usb_fifo_pkt_writer`

## Requirements
- R1: After reset the strobe `wr_n_o` is high (inactive), `be_o` is zero, `done_o` is low and `src_ready_o` is low.
- R2: The maximum packet size is 512 bytes when `superspeed_i` is 0 and 1024 bytes when it is 1. The value is captured with the start pulse, and later changes to the input do not affect the running transfer.
- R3: Every packet except the final one carries exactly the maximum packet size. Within a packet the strobe stays low, and it rises only in the cycle after the packet's last word is accepted.
- R4: The final packet of a transfer whose length is not a multiple of the maximum is shorter than the maximum. In its last word, byte enable bit i enables data bits [8i+7:8i], and only the low (len mod 4) bits are set (all four when the remainder is zero). Bytes leave in stream order, and the lowest byte lane carries the earliest byte.
- R5: When the length is a multiple of the maximum packet size (zero included), the full packets are followed by one extra write with `be_o` = 4'b0001 and data byte 0x00.
- R6: A word transfers on a rising edge where `wr_n_o` and `space_n_i` are both low. The strobe falls only after a cycle in which `space_n_i` was low. If `space_n_i` goes high mid-packet, the strobe is held low and the word is held.
- R7: `done_o` is high for exactly one cycle, in the cycle after the final write of the transfer is accepted.
- R8: `src_ready_o` is high only while a packet is being staged and never while the strobe is low. A transfer consumes exactly ceil(len/4) source words. The unused upper bytes of the last source word are discarded.
- R9: A start pulse while a transfer is in progress is ignored. It produces no writes and consumes no source words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a transfer |
| len_i | input | LEN_W | Transfer length in bytes, captured with start |
| superspeed_i | input | 1 | 1 selects 1024-byte packets, 0 selects 512-byte packets |
| src_data_i | input | DATA_W | Source word, earliest byte in the low lane |
| src_valid_i | input | 1 | Source word valid |
| src_ready_o | output | 1 | Writer accepts a source word |
| space_n_i | input | 1 | Active-low slave space-available flag |
| wr_n_o | output | 1 | Active-low write strobe to the slave |
| be_o | output | DATA_W/8 | Per-byte enables of the current write |
| data_o | output | DATA_W | Write data to the slave |
| done_o | output | 1 | One-cycle pulse after the final write is accepted |

## Verification
A scoreboard checks every accepted byte and every packet length. Its stimulus patterns are chosen so that the run separates the different ways a transfer can end:
- A length with a whole-word short tail, a length with a one- to three-byte tail, an exact multiple of the packet size, and zero length. Together these separate the plain short-packet ending, the partial byte-enable ending and the added one-byte terminator.
- Both speed modes, with the mode input flipped right after start. This shows that the packet size comes from the captured value.
- A slave that negates space at random points, a source with gaps, and a transfer long enough to fill the slave buffer. These show that the strobe is released only at packet boundaries and that source gaps never reach the bus.
- A start pulse issued mid-transfer, which must leave no trace on the outputs.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_FILL,
        ST_ARM,
        ST_BURST,
        ST_TERM
    } wrp_state_e;

endpackage

// File: rtl/wrp_pkt_sizer.sv
module wrp_pkt_sizer #(
    parameter int LEN_W  = 20,
    parameter int BYTES  = 4,
    parameter int HS_PKT = 512,
    parameter int SS_PKT = 1024,
    parameter int AW     = 8
) (
    input  logic [LEN_W-1:0] rem_i,
    input  logic             ss_i,
    output logic [LEN_W-1:0] pkt_bytes_o,
    output logic [AW-1:0]    last_idx_o,
    output logic [BYTES-1:0] last_be_o,
    output logic             full_o
);
    localparam int SH = $clog2(BYTES);

    logic [LEN_W-1:0] pmax;
    logic [LEN_W-1:0] minus1;
    logic [SH-1:0]    rbytes;

    always_comb begin
        pmax        = ss_i ? LEN_W'(SS_PKT) : LEN_W'(HS_PKT);
        full_o      = (rem_i >= pmax);
        pkt_bytes_o = full_o ? pmax : rem_i;
        minus1      = (pkt_bytes_o == '0) ? '0 : pkt_bytes_o - LEN_W'(1);
        last_idx_o  = AW'(minus1 >> SH);
        rbytes      = pkt_bytes_o[SH-1:0];
        for (int i = 0; i < BYTES; i++) begin
            last_be_o[i] = (rbytes == '0) || (i < int'(rbytes));
        end
    end

endmodule

// File: rtl/wrp_stage_ram.sv
module wrp_stage_ram #(
    parameter int DW    = 32,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/wrp_ctrl.sv
module wrp_ctrl
    import wrp_pkg::*;
#(
    parameter int LEN_W  = 20,
    parameter int DATA_W = 32,
    parameter int BYTES  = 4,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              ss_i,
    input  logic              src_valid_i,
    output logic              src_ready_o,
    output logic              ram_we_o,
    output logic [AW-1:0]     ram_waddr_o,
    output logic [AW-1:0]     ram_raddr_o,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic [LEN_W-1:0]  rem_o,
    output logic              ss_o,
    input  logic [LEN_W-1:0]  pkt_bytes_i,
    input  logic [AW-1:0]     last_idx_i,
    input  logic [BYTES-1:0]  last_be_i,
    input  logic              full_i,
    input  logic              space_n_i,
    output logic              wr_n_o,
    output logic [BYTES-1:0]  be_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);
    wrp_state_e state_q, state_d;

    logic [LEN_W-1:0] rem_q;
    logic             ss_q;
    logic [AW-1:0]    last_idx_q;
    logic [BYTES-1:0] last_be_q;
    logic             full_q;
    logic [AW-1:0]    widx_q;
    logic [AW-1:0]    ridx_q;
    logic [AW-1:0]    ridx_inc;
    logic             accept;
    logic             burst_end;

    assign ridx_inc    = AW'(ridx_q + 1'b1);
    assign accept      = !space_n_i;
    assign burst_end   = accept && (ridx_q == last_idx_q);
    assign src_ready_o = (state_q == ST_FILL);
    assign ram_we_o    = (state_q == ST_FILL) && src_valid_i;
    assign ram_waddr_o = widx_q;
    assign ram_raddr_o = (state_q == ST_BURST) ? ridx_inc : '0;
    assign rem_o       = rem_q;
    assign ss_o        = ss_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_PLAN;
            ST_PLAN:  state_d = (rem_q == '0) ? ST_TERM : ST_FILL;
            ST_FILL:  if (src_valid_i && (widx_q == last_idx_q)) state_d = ST_ARM;
            ST_ARM:   if (accept) state_d = ST_BURST;
            ST_BURST: begin
                if (burst_end) begin
                    if (rem_q != '0)  state_d = ST_PLAN;
                    else if (full_q)  state_d = ST_TERM;
                    else              state_d = ST_IDLE;
                end
            end
            ST_TERM:  if (!wr_n_o && accept) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_n_o     <= 1'b1;
            be_o       <= '0;
            data_o     <= '0;
            done_o     <= 1'b0;
            rem_q      <= '0;
            ss_q       <= 1'b0;
            last_idx_q <= '0;
            last_be_q  <= '0;
            full_q     <= 1'b0;
            widx_q     <= '0;
            ridx_q     <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        rem_q <= len_i;
                        ss_q  <= ss_i;
                    end
                end
                ST_PLAN: begin
                    if (rem_q != '0) begin
                        rem_q      <= rem_q - pkt_bytes_i;
                        last_idx_q <= last_idx_i;
                        last_be_q  <= last_be_i;
                        full_q     <= full_i;
                        widx_q     <= '0;
                    end
                end
                ST_FILL: begin
                    if (src_valid_i) widx_q <= AW'(widx_q + 1'b1);
                end
                ST_ARM: begin
                    if (accept) begin
                        wr_n_o <= 1'b0;
                        data_o <= ram_rdata_i;
                        be_o   <= (last_idx_q == '0) ? last_be_q : '1;
                        ridx_q <= '0;
                    end
                end
                ST_BURST: begin
                    if (burst_end) begin
                        wr_n_o <= 1'b1;
                        be_o   <= '0;
                        done_o <= (rem_q == '0) && !full_q;
                    end else if (accept) begin
                        ridx_q <= ridx_inc;
                        data_o <= ram_rdata_i;
                        be_o   <= (ridx_inc == last_idx_q) ? last_be_q : '1;
                    end
                end
                ST_TERM: begin
                    if (wr_n_o && accept) begin
                        wr_n_o <= 1'b0;
                        be_o   <= BYTES'(1);
                        data_o <= '0;
                    end else if (!wr_n_o && accept) begin
                        wr_n_o <= 1'b1;
                        be_o   <= '0;
                        done_o <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: strobe only falls after the slave showed space
    assert_strobe_after_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n_o) |-> $past(!space_n_i));
    // R6: an active strobe always enables at least one byte
    assert_strobe_has_bytes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> (be_o != '0));
    // R3: release happens only right after an accepted write
    assert_release_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> $past(!space_n_i));
    // R4: an accepted partial-width write ends the packet
    assert_partial_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_o && !space_n_i && (be_o != '1)) |=> wr_n_o);
    // R8: source is never taken while writing
    assert_ready_not_writing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_ready_o && !wr_n_o));
    // R7: done is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/usb_fifo_pkt_writer.sv
module usb_fifo_pkt_writer #(
    parameter int LEN_W  = 20,
    parameter int DATA_W = 32,
    parameter int HS_PKT = 512,
    parameter int SS_PKT = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic                superspeed_i,
    input  logic [DATA_W-1:0]   src_data_i,
    input  logic                src_valid_i,
    output logic                src_ready_o,
    input  logic                space_n_i,
    output logic                wr_n_o,
    output logic [DATA_W/8-1:0] be_o,
    output logic [DATA_W-1:0]   data_o,
    output logic                done_o
);
    localparam int BYTES = DATA_W / 8;
    localparam int DEPTH = SS_PKT / BYTES;
    localparam int AW    = $clog2(DEPTH);

    logic             ram_we;
    logic [AW-1:0]    ram_waddr;
    logic [AW-1:0]    ram_raddr;
    logic [DATA_W-1:0] ram_rdata;
    logic [LEN_W-1:0] rem;
    logic             ss_lat;
    logic [LEN_W-1:0] pkt_bytes;
    logic [AW-1:0]    last_idx;
    logic [BYTES-1:0] last_be;
    logic             pkt_full;

    wrp_pkt_sizer #(
        .LEN_W(LEN_W), .BYTES(BYTES), .HS_PKT(HS_PKT), .SS_PKT(SS_PKT), .AW(AW)
    ) u_sizer (
        .rem_i       (rem),
        .ss_i        (ss_lat),
        .pkt_bytes_o (pkt_bytes),
        .last_idx_o  (last_idx),
        .last_be_o   (last_be),
        .full_o      (pkt_full)
    );

    wrp_stage_ram #(
        .DW(DATA_W), .DEPTH(DEPTH), .AW(AW)
    ) u_stage (
        .clk     (clk),
        .we_i    (ram_we),
        .waddr_i (ram_waddr),
        .wdata_i (src_data_i),
        .raddr_i (ram_raddr),
        .rdata_o (ram_rdata)
    );

    wrp_ctrl #(
        .LEN_W(LEN_W), .DATA_W(DATA_W), .BYTES(BYTES), .AW(AW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .len_i       (len_i),
        .ss_i        (superspeed_i),
        .src_valid_i (src_valid_i),
        .src_ready_o (src_ready_o),
        .ram_we_o    (ram_we),
        .ram_waddr_o (ram_waddr),
        .ram_raddr_o (ram_raddr),
        .ram_rdata_i (ram_rdata),
        .rem_o       (rem),
        .ss_o        (ss_lat),
        .pkt_bytes_i (pkt_bytes),
        .last_idx_i  (last_idx),
        .last_be_i   (last_be),
        .full_i      (pkt_full),
        .space_n_i   (space_n_i),
        .wr_n_o      (wr_n_o),
        .be_o        (be_o),
        .data_o      (data_o),
        .done_o      (done_o)
    );

endmodule

// File: tb/usb_fifo_pkt_writer_bench.sv
module usb_fifo_pkt_writer_bench;
    localparam int LEN_W   = 20;
    localparam int BUF_MAX = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic        superspeed_i = 1'b0;
    logic [31:0] src_data_i = '0;
    logic        src_valid_i = 1'b0;
    logic        src_ready_o;
    logic        space_n_i = 1'b1;
    logic        wr_n_o;
    logic [3:0]  be_o;
    logic [31:0] data_o;
    logic        done_o;

    always #2 clk = ~clk;

    usb_fifo_pkt_writer u_usb_fifo_pkt_writer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .superspeed_i(superspeed_i), .src_data_i(src_data_i),
        .src_valid_i(src_valid_i), .src_ready_o(src_ready_o),
        .space_n_i(space_n_i), .wr_n_o(wr_n_o), .be_o(be_o),
        .data_o(data_o), .done_o(done_o)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int tid = 0;

    logic [7:0] byte_q[$];
    int         pkt_q[$];

    // source state
    int src_idx = 0;
    int src_words = 0;
    bit src_hs = 0;
    bit gap_en = 0;

    // slave model state
    bit stall_en = 0;
    int fill = 0;
    int drain = 0;
    int pkt_cnt = 0;
    int cur_max = 512;
    bit prev_acc = 0;
    bit prev_low = 0;
    bit prev_space = 0;
    bit prev_final = 0;
    int done_cnt = 0;
    int write_cnt = 0;

    function automatic logic [31:0] pat(int t, int k);
        return (32'(t) * 32'h9E3779B1) ^ (32'(k) * 32'h01000193) ^ 32'h5A5A0F0F;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // source driver
    always @(negedge clk) begin
        if (src_hs) src_idx = src_idx + 1;
        src_valid_i = (src_idx < src_words) && !(gap_en && (cyc % 3 == 1));
        src_data_i  = pat(tid, src_idx);
        src_hs      = src_valid_i && src_ready_o;
    end

    // slave model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] expw;
            logic [31:0] mask;
            int nb;
            bit contig;
            bit seen0;
            // strobe release: ends a packet
            if (prev_low && wr_n_o) begin
                int exp_len;
                vectors++;
                exp_len = (pkt_q.size() > 0) ? pkt_q.pop_front() : -1;
                if (!prev_acc || pkt_cnt != exp_len) begin
                    miscompares++;
                    $display("FAIL R3 packet length %0d (release after accept %0d), expected %0d", pkt_cnt, prev_acc, exp_len);
                end
                if (pkt_cnt < cur_max) fill = 0;
                pkt_cnt = 0;
            end
            // strobe fall only after space shown
            if (!prev_low && !wr_n_o) begin
                vectors++;
                if (!prev_space) begin
                    miscompares++;
                    $display("FAIL R6 strobe fell with space flag %0d, expected 0", !prev_space);
                end
            end
            // done pulse
            if (done_o || prev_final) begin
                vectors++;
                if (done_o != prev_final) begin
                    miscompares++;
                    $display("FAIL R7 done_o %0d, expected %0d", done_o, prev_final);
                end
                if (done_o) done_cnt++;
            end
            // space flag for upcoming edge
            if (drain > 0) begin
                drain--;
                if (drain == 0) fill = 0;
            end
            space_n_i = (fill >= BUF_MAX) || (stall_en && (cyc % 5 == 2));
            prev_space = !space_n_i;
            // acceptance at upcoming edge
            prev_final = 0;
            prev_acc = !wr_n_o && !space_n_i;
            if (prev_acc) begin
                vectors++;
                write_cnt++;
                nb = $countones(be_o);
                contig = 1; seen0 = 0;
                expw = '0; mask = '0;
                for (int i = 0; i < 4; i++) begin
                    if (!be_o[i]) seen0 = 1;
                    else if (seen0) contig = 0;
                    if (be_o[i]) begin
                        mask[8*i +: 8] = 8'hFF;
                        expw[8*i +: 8] = (byte_q.size() > 0) ? byte_q.pop_front() : 8'hxx;
                    end
                end
                if (!contig || ((data_o & mask) !== expw)) begin
                    miscompares++;
                    $display("FAIL R4 write data %h be %b, expected %h", data_o & mask, be_o, expw);
                end
                pkt_cnt += nb;
                fill += nb;
                if (fill >= BUF_MAX) drain = 30;
                prev_final = (byte_q.size() == 0);
            end
            prev_low = !wr_n_o;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_xfer(int len, bit ss, bit stall, bit gap, bit poke);
        int pmax;
        int d0;
        int w0;
        @(negedge clk);
        tid++;
        pmax = ss ? 1024 : 512;
        cur_max = pmax;
        for (int b = 0; b < len; b++) begin
            logic [31:0] w;
            w = pat(tid, b / 4);
            byte_q.push_back(w[8*(b%4) +: 8]);
        end
        for (int p = 0; p < len / pmax; p++) pkt_q.push_back(pmax);
        if (len % pmax != 0) pkt_q.push_back(len % pmax);
        else begin
            byte_q.push_back(8'h00); // R5 terminator byte
            pkt_q.push_back(1);
        end
        src_idx = 0;
        src_words = (len + 3) / 4;
        stall_en = stall;
        gap_en = gap;
        d0 = done_cnt;
        start_i = 1'b1;
        len_i = LEN_W'(len);
        superspeed_i = ss;
        @(negedge clk);
        start_i = 1'b0;
        superspeed_i = !ss; // R2: later mode changes must not matter
        if (poke) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1; // R9: start while busy
            len_i = LEN_W'(8);
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        check(src_idx == src_words, "R8 source words", src_idx, src_words);
        check(byte_q.size() == 0, "R4 bytes left", byte_q.size(), 0);
        check(pkt_q.size() == 0, "R3 packets left", pkt_q.size(), 0);
        check(src_ready_o == 1'b0, "R8 ready after done", src_ready_o, 0);
        if (poke) begin
            w0 = write_cnt;
            repeat (100) @(negedge clk);
            check(write_cnt == w0, "R9 writes after ignored start", write_cnt, w0);
            check(src_idx == src_words, "R9 source words after ignored start", src_idx, src_words);
        end
        stall_en = 0;
        gap_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(wr_n_o == 1'b1, "R1 wr_n_o", wr_n_o, 1);
        check(be_o == 4'b0, "R1 be_o", be_o, 0);
        check(done_o == 1'b0, "R1 done_o", done_o, 0);
        check(src_ready_o == 1'b0, "R1 src_ready_o", src_ready_o, 0);
        run_xfer(1300, 0, 0, 0, 0); // R3 R4 high speed, whole-word short tail
        run_xfer(2051, 1, 0, 0, 0); // R2 R4 super speed, 3-byte tail
        run_xfer(1024, 0, 0, 0, 0); // R5 multiple of 512
        run_xfer(0,    1, 0, 0, 0); // R5 zero length
        run_xfer(1,    1, 0, 0, 0); // R4 single byte
        run_xfer(1030, 0, 1, 0, 0); // R6 stalled slave
        run_xfer(1538, 1, 0, 1, 1); // R8 gaps, R9 start while busy
        run_xfer(5000, 1, 1, 0, 0); // R3 R6 buffer-full pauses
        run_xfer(2048, 1, 0, 0, 0); // R5 multiple of 1024
        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule